// File: doc/BRIEF.md
# Programmable Down-Counting Timer Channel

This block is one timer channel reached through a word-addressed register port with separate write and read strobes. A counter decrements on prescaled ticks of an external tick-enable input. The channel can run in one of three modes: it can wrap freely through its full range, it can reload from a stored value each time it expires, or it can expire once and then park at zero. The counter can be 16 or 32 bits wide, and the tick rate can be divided by 1, 16 or 256.

Each expiry sets a raw interrupt flag. The flag is cleared by writing any value to a clear offset. The interrupt output is that flag gated by an enable bit. Software can change the reload value in two ways. One write reloads the counter at once. The other write only replaces the value that the next natural reload will use.

Top module: `cntdn_timer`

## Requirements
- R1: After synchronous reset the control register reads 0x20 (interrupt enable only, timer stopped). The count, the stored load value and the raw flag all read 0, and irq is low.
- R2: The control register is at word offset 2 and reads back the low 8 bits written. Its fields are: bit 7 run, bit 6 periodic, bit 5 interrupt enable, bits 3:2 prescale select, bit 1 wide (32-bit) count, bit 0 one-shot. One-shot takes precedence over periodic. With both bits clear the mode is free-running.
- R3: While run is set, the count drops by exactly one on each prescaled tick. It holds while tick_en is low or run is clear.
- R4: Prescale select 01 yields one step per 16 tick_en cycles and 10 yields one per 256. Both 00 and 11 yield one per tick. A control write restarts the prescale phase.
- R5: In periodic mode, a step taken while the count is 0 is an expiry. The expiry sets the raw flag and reloads the stored load value.
- R6: In one-shot mode, the first step at count 0 sets the raw flag and the count stays 0. Later steps raise no further expiry until the load offset or the control register is written.
- R7: In free-running mode an expiry wraps the count to 0xFFFF (16-bit) or 0xFFFFFFFF (32-bit). A write to the load offset in this mode sets the count to that wrap value, not to the written data.
- R8: A write to offset 0 stores the value and reloads the count at once. A write to offset 6 stores the value and leaves the count untouched. Reads of offset 0 and offset 6 both return the stored value.
- R9: Offset 1 reads the count, limited to its low 16 bits in 16-bit mode. A write to offset 1 leaves the count unchanged.
- R10: Any write to offset 3 clears the raw flag. If an expiry happens in the same cycle, the expiry wins.
- R11: Offset 4 reads the raw flag in bit 0. Offset 5 and the irq pin both equal the raw flag ANDed with the interrupt enable bit.
- R12: rdata is 0 while rd_en is low and for unmapped offset 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Base count-rate enable |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Word offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational |
| irq | output | 1 | Level interrupt, raw flag masked by enable |

## Verification
The counting path is driven with continuous tick runs, idle gaps with tick_en low, and runs with run cleared. These separate a counter that follows the prescaled step from one that counts clocks or ignores the run bit. Each mode is taken through at least one expiry. Periodic reload, one-shot parking and the free-running wrap at both widths therefore produce distinct values, and a mode decoder that is wrong shows up as the wrong post-expiry count. Tick runs of 15, 16, 32, 255 and 256 cycles land exactly on and just short of the prescale boundaries. The immediate and background load writes are each followed by a read of the count, which tells the two reload paths apart.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 3;
    localparam int PRE_W  = 8;
    localparam int HALF_W = 16;

    localparam logic [ADDR_W-1:0] OFF_LOAD   = 3'd0;
    localparam logic [ADDR_W-1:0] OFF_VALUE  = 3'd1;
    localparam logic [ADDR_W-1:0] OFF_CTRL   = 3'd2;
    localparam logic [ADDR_W-1:0] OFF_ICLR   = 3'd3;
    localparam logic [ADDR_W-1:0] OFF_RAW    = 3'd4;
    localparam logic [ADDR_W-1:0] OFF_MSK    = 3'd5;
    localparam logic [ADDR_W-1:0] OFF_BGLOAD = 3'd6;

    // control byte, most significant field first
    typedef struct packed {
        logic       run;
        logic       periodic;
        logic       irq_en;
        logic       spare;
        logic [1:0] presc;
        logic       wide;
        logic       oneshot;
    } ctrl_t;

    localparam logic [7:0] CTRL_RESET = 8'h20;

    typedef enum logic [1:0] {
        MODE_FREE     = 2'd0,
        MODE_PERIODIC = 2'd1,
        MODE_ONESHOT  = 2'd2
    } mode_e;

    function automatic mode_e mode_of(ctrl_t c);
        if (c.oneshot)       return MODE_ONESHOT;
        else if (c.periodic) return MODE_PERIODIC;
        else                 return MODE_FREE;
    endfunction

    function automatic logic [PRE_W-1:0] presc_last(logic [1:0] sel);
        case (sel)
            2'b01:   return PRE_W'(15);
            2'b10:   return PRE_W'(255);
            default: return '0;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] width_mask(logic wide);
        return wide ? '1 : {{(DATA_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
    endfunction

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale
    import tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_en,
    input  logic       run,
    input  logic       restart,
    input  logic [1:0] presc,
    output logic       step
);
    logic [PRE_W-1:0] phase_q;
    logic [PRE_W-1:0] last;

    assign last = presc_last(presc);
    assign step = run && tick_en && (phase_q == last);

    always_ff @(posedge clk) begin
        if (rst || restart || !run) begin
            phase_q <= '0;
        end else if (tick_en) begin
            phase_q <= (phase_q == last) ? '0 : phase_q + 1'b1;
        end
    end

    // R4: a step only ever comes from a tick while running
    a_r4_step_gated: assert property (@(posedge clk) disable iff (rst)
        step |-> (tick_en && run));

    // R4: the phase never passes the selected divide boundary
    a_r4_phase_range: assert property (@(posedge clk) disable iff (rst)
        phase_q <= last);

endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  mode_e             mode,
    input  logic              wide,
    input  logic              load_now,
    input  logic              ctrl_wr,
    input  logic [DATA_W-1:0] load_val,
    input  logic [DATA_W-1:0] reload_val,
    output logic [DATA_W-1:0] count_q,
    output logic              expire
);
    logic [DATA_W-1:0] mask;
    logic              at_zero;
    logic              done_q;

    assign mask    = width_mask(wide);
    assign at_zero = (count_q & mask) == '0;
    assign expire  = step && at_zero && !(mode == MODE_ONESHOT && done_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (load_now) begin
            count_q <= (mode == MODE_FREE) ? mask : load_val;
        end else if (step) begin
            if (at_zero) begin
                case (mode)
                    MODE_FREE:     count_q <= mask;
                    MODE_PERIODIC: count_q <= reload_val;
                    default:       count_q <= '0;
                endcase
            end else begin
                count_q <= (count_q - 1'b1) & mask;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || load_now || ctrl_wr) begin
            done_q <= 1'b0;
        end else if (step && at_zero && mode == MODE_ONESHOT) begin
            done_q <= 1'b1;
        end
    end

    // R3: no step and no load write means the count holds
    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        (!step && !load_now) |=> $stable(count_q));

    // R5: a periodic expiry loads the stored reload value
    a_r5_reload: assert property (@(posedge clk) disable iff (rst)
        (expire && mode == MODE_PERIODIC && !load_now) |=> count_q == $past(reload_val));

    // R6: one-shot parks at zero
    a_r6_park: assert property (@(posedge clk) disable iff (rst)
        (step && at_zero && mode == MODE_ONESHOT && !load_now) |=> count_q == '0);

    // R7: free-running expiry wraps to the width's maximum
    a_r7_wrap: assert property (@(posedge clk) disable iff (rst)
        (expire && mode == MODE_FREE && !load_now) |=> count_q == $past(mask));

    // R8: an immediate load in a reloading mode takes the written data
    a_r8_load: assert property (@(posedge clk) disable iff (rst)
        (load_now && mode != MODE_FREE) |=> count_q == $past(load_val));

endmodule

// File: rtl/cntdn_timer.sv
module cntdn_timer
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    ctrl_t             ctrl_q;
    logic [DATA_W-1:0] load_q;
    logic              raw_q;
    logic              step;
    logic              expire;
    logic [DATA_W-1:0] count;
    logic [DATA_W-1:0] shown;
    mode_e             mode;

    logic wr_load, wr_ctrl, wr_iclr, wr_bg;

    assign wr_load = wr_en && addr == OFF_LOAD;
    assign wr_ctrl = wr_en && addr == OFF_CTRL;
    assign wr_iclr = wr_en && addr == OFF_ICLR;
    assign wr_bg   = wr_en && addr == OFF_BGLOAD;
    assign mode    = mode_of(ctrl_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= ctrl_t'(CTRL_RESET);
            load_q <= '0;
            raw_q  <= 1'b0;
        end else begin
            if (wr_ctrl)           ctrl_q <= ctrl_t'(wdata[7:0]);
            if (wr_load || wr_bg)  load_q <= wdata;
            if (expire)            raw_q  <= 1'b1;
            else if (wr_iclr)      raw_q  <= 1'b0;
        end
    end

    tmr_prescale u_presc (
        .clk     (clk),
        .rst     (rst),
        .tick_en (tick_en),
        .run     (ctrl_q.run),
        .restart (wr_ctrl),
        .presc   (ctrl_q.presc),
        .step    (step)
    );

    tmr_core u_core (
        .clk        (clk),
        .rst        (rst),
        .step       (step),
        .mode       (mode),
        .wide       (ctrl_q.wide),
        .load_now   (wr_load),
        .ctrl_wr    (wr_ctrl),
        .load_val   (wdata),
        .reload_val (load_q),
        .count_q    (count),
        .expire     (expire)
    );

    assign shown = count & width_mask(ctrl_q.wide);
    assign irq   = raw_q & ctrl_q.irq_en;

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (addr)
                OFF_LOAD, OFF_BGLOAD: rdata = load_q;
                OFF_VALUE:            rdata = shown;
                OFF_CTRL:             rdata = {{(DATA_W-8){1'b0}}, ctrl_q};
                OFF_RAW:              rdata = {{(DATA_W-1){1'b0}}, raw_q};
                OFF_MSK:              rdata = {{(DATA_W-1){1'b0}}, irq};
                default:              rdata = '0;
            endcase
        end
    end

    // R2: a control write lands in the register on the next cycle
    a_r2_ctrl_wr: assert property (@(posedge clk) disable iff (rst)
        wr_ctrl |=> ctrl_q == $past(wdata[7:0]));

    // R5: every expiry leaves the raw flag set
    a_r5_raw_set: assert property (@(posedge clk) disable iff (rst)
        expire |=> raw_q);

    // R10: a clear write without a coincident expiry drops the flag
    a_r10_clear: assert property (@(posedge clk) disable iff (rst)
        (wr_iclr && !expire) |=> !raw_q);

    // R11: masked read path agrees with the interrupt pin
    a_r11_msk_read: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == OFF_MSK) |-> rdata == {{(DATA_W-1){1'b0}}, irq});

    // R9: writing the value offset does not move the count
    a_r9_value_ro: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == OFF_VALUE && !step) |=> $stable(count));

endmodule

// File: tb/cntdn_timer_bench.sv
`timescale 1ns/1ps
module cntdn_timer_bench;

    localparam logic [2:0] OP_WR   = 3'd0;
    localparam logic [2:0] OP_RD   = 3'd1;
    localparam logic [2:0] OP_TICK = 3'd2;
    localparam logic [2:0] OP_IDLE = 3'd3;
    localparam logic [2:0] OP_IRQ  = 3'd4;

    localparam logic [2:0] A_LOAD = 3'd0, A_VAL = 3'd1, A_CTRL = 3'd2, A_ICLR = 3'd3;
    localparam logic [2:0] A_RAW  = 3'd4, A_MSK = 3'd5, A_BG   = 3'd6, A_NONE = 3'd7;

    typedef struct packed {
        logic [2:0]  op;
        logic [2:0]  a;
        logic [31:0] d;
        logic [31:0] e;
        logic [7:0]  req;
    } vec_t;

    localparam int NA = 54;
    localparam logic [77:0] TAB_A [NA] = '{
        {OP_RD,   A_CTRL, 32'h0,  32'h20, 8'd1},   // R1
        {OP_RD,   A_VAL,  32'h0,  32'h0,  8'd1},   // R1
        {OP_RD,   A_RAW,  32'h0,  32'h0,  8'd1},   // R1
        {OP_IRQ,  A_NONE, 32'h0,  32'h0,  8'd1},   // R1
        {OP_WR,   A_CTRL, 32'h62, 32'h0,  8'd2},   // R2 periodic, stopped
        {OP_WR,   A_LOAD, 32'h5,  32'h0,  8'd8},
        {OP_RD,   A_VAL,  32'h0,  32'h5,  8'd8},   // R8 immediate reload
        {OP_RD,   A_LOAD, 32'h0,  32'h5,  8'd8},
        {OP_TICK, A_NONE, 32'd3,  32'h0,  8'd3},
        {OP_RD,   A_VAL,  32'h0,  32'h5,  8'd3},   // R3 stopped holds
        {OP_WR,   A_CTRL, 32'hE2, 32'h0,  8'd2},
        {OP_TICK, A_NONE, 32'd3,  32'h0,  8'd3},
        {OP_RD,   A_VAL,  32'h0,  32'h2,  8'd3},   // R3 one per tick
        {OP_IDLE, A_NONE, 32'd4,  32'h0,  8'd3},
        {OP_RD,   A_VAL,  32'h0,  32'h2,  8'd3},   // R3 tick_en low holds
        {OP_TICK, A_NONE, 32'd2,  32'h0,  8'd3},
        {OP_RD,   A_VAL,  32'h0,  32'h0,  8'd3},
        {OP_RD,   A_RAW,  32'h0,  32'h0,  8'd5},   // R5 zero is not expiry yet
        {OP_TICK, A_NONE, 32'd1,  32'h0,  8'd5},
        {OP_RD,   A_VAL,  32'h0,  32'h5,  8'd5},   // R5 reload
        {OP_RD,   A_RAW,  32'h0,  32'h1,  8'd5},
        {OP_RD,   A_MSK,  32'h0,  32'h1,  8'd11},  // R11
        {OP_IRQ,  A_NONE, 32'h0,  32'h1,  8'd11},
        {OP_WR,   A_BG,   32'h3,  32'h0,  8'd8},
        {OP_RD,   A_VAL,  32'h0,  32'h5,  8'd8},   // R8 background keeps count
        {OP_RD,   A_LOAD, 32'h0,  32'h3,  8'd8},
        {OP_RD,   A_BG,   32'h0,  32'h3,  8'd8},
        {OP_TICK, A_NONE, 32'd6,  32'h0,  8'd8},
        {OP_RD,   A_VAL,  32'h0,  32'h3,  8'd8},   // R8 new value at next reload
        {OP_WR,   A_ICLR, 32'h0,  32'h0,  8'd10},
        {OP_RD,   A_RAW,  32'h0,  32'h0,  8'd10},  // R10
        {OP_IRQ,  A_NONE, 32'h0,  32'h0,  8'd10},
        {OP_WR,   A_CTRL, 32'hC2, 32'h0,  8'd11},  // interrupt enable off
        {OP_TICK, A_NONE, 32'd4,  32'h0,  8'd5},
        {OP_RD,   A_VAL,  32'h0,  32'h3,  8'd5},
        {OP_RD,   A_RAW,  32'h0,  32'h1,  8'd11},  // R11 raw still set
        {OP_RD,   A_MSK,  32'h0,  32'h0,  8'd11},  // R11 masked
        {OP_IRQ,  A_NONE, 32'h0,  32'h0,  8'd11},
        {OP_RD,   A_CTRL, 32'h0,  32'hC2, 8'd2},   // R2
        {OP_WR,   A_VAL,  32'h1234, 32'h0, 8'd9},
        {OP_RD,   A_VAL,  32'h0,  32'h3,  8'd9},   // R9 write ignored
        {OP_WR,   A_CTRL, 32'hA3, 32'h0,  8'd6},   // one-shot
        {OP_WR,   A_ICLR, 32'h0,  32'h0,  8'd6},
        {OP_WR,   A_LOAD, 32'h2,  32'h0,  8'd6},
        {OP_TICK, A_NONE, 32'd2,  32'h0,  8'd6},
        {OP_RD,   A_VAL,  32'h0,  32'h0,  8'd6},
        {OP_RD,   A_RAW,  32'h0,  32'h0,  8'd6},
        {OP_TICK, A_NONE, 32'd1,  32'h0,  8'd6},
        {OP_RD,   A_RAW,  32'h0,  32'h1,  8'd6},   // R6 single expiry
        {OP_RD,   A_VAL,  32'h0,  32'h0,  8'd6},
        {OP_WR,   A_ICLR, 32'h0,  32'h0,  8'd6},
        {OP_TICK, A_NONE, 32'd5,  32'h0,  8'd6},
        {OP_RD,   A_RAW,  32'h0,  32'h0,  8'd6},   // R6 no repeat
        {OP_RD,   A_VAL,  32'h0,  32'h0,  8'd6}
    };

    localparam int NB = 43;
    localparam logic [77:0] TAB_B [NB] = '{
        {OP_WR,   A_CTRL, 32'hA0, 32'h0,  8'd7},   // free, 16-bit
        {OP_TICK, A_NONE, 32'd1,  32'h0,  8'd7},
        {OP_RD,   A_VAL,  32'h0,  32'hFFFF, 8'd7}, // R7 16-bit wrap
        {OP_RD,   A_RAW,  32'h0,  32'h1,  8'd7},
        {OP_TICK, A_NONE, 32'd2,  32'h0,  8'd7},
        {OP_RD,   A_VAL,  32'h0,  32'hFFFD, 8'd7},
        {OP_WR,   A_LOAD, 32'h7,  32'h0,  8'd7},
        {OP_RD,   A_VAL,  32'h0,  32'hFFFF, 8'd7}, // R7 load ignored in free mode
        {OP_RD,   A_LOAD, 32'h0,  32'h7,  8'd8},
        {OP_WR,   A_CTRL, 32'h60, 32'h0,  8'd9},
        {OP_WR,   A_LOAD, 32'h12345, 32'h0, 8'd9},
        {OP_RD,   A_VAL,  32'h0,  32'h2345, 8'd9}, // R9 low half only
        {OP_RD,   A_LOAD, 32'h0,  32'h12345, 8'd8},
        {OP_WR,   A_CTRL, 32'hE0, 32'h0,  8'd9},
        {OP_TICK, A_NONE, 32'd1,  32'h0,  8'd9},
        {OP_RD,   A_VAL,  32'h0,  32'h2344, 8'd9},
        {OP_WR,   A_CTRL, 32'h42, 32'h0,  8'd7},
        {OP_WR,   A_LOAD, 32'h0,  32'h0,  8'd7},
        {OP_WR,   A_ICLR, 32'h0,  32'h0,  8'd7},
        {OP_WR,   A_CTRL, 32'h82, 32'h0,  8'd7},   // free, 32-bit, no irq enable
        {OP_TICK, A_NONE, 32'd1,  32'h0,  8'd7},
        {OP_RD,   A_VAL,  32'h0,  32'hFFFFFFFF, 8'd7}, // R7 32-bit wrap
        {OP_RD,   A_RAW,  32'h0,  32'h1,  8'd7},
        {OP_IRQ,  A_NONE, 32'h0,  32'h0,  8'd11},
        {OP_WR,   A_CTRL, 32'h66, 32'h0,  8'd4},
        {OP_WR,   A_LOAD, 32'hA,  32'h0,  8'd4},
        {OP_WR,   A_CTRL, 32'hE6, 32'h0,  8'd4},   // divide by 16
        {OP_TICK, A_NONE, 32'd15, 32'h0,  8'd4},
        {OP_RD,   A_VAL,  32'h0,  32'hA,  8'd4},   // R4 not yet
        {OP_TICK, A_NONE, 32'd1,  32'h0,  8'd4},
        {OP_RD,   A_VAL,  32'h0,  32'h9,  8'd4},
        {OP_TICK, A_NONE, 32'd32, 32'h0,  8'd4},
        {OP_RD,   A_VAL,  32'h0,  32'h7,  8'd4},
        {OP_WR,   A_CTRL, 32'hEA, 32'h0,  8'd4},   // divide by 256
        {OP_TICK, A_NONE, 32'd255, 32'h0, 8'd4},
        {OP_RD,   A_VAL,  32'h0,  32'h7,  8'd4},   // R4 one short
        {OP_TICK, A_NONE, 32'd1,  32'h0,  8'd4},
        {OP_RD,   A_VAL,  32'h0,  32'h6,  8'd4},
        {OP_WR,   A_CTRL, 32'hEE, 32'h0,  8'd4},   // select 11
        {OP_TICK, A_NONE, 32'd1,  32'h0,  8'd4},
        {OP_RD,   A_VAL,  32'h0,  32'h5,  8'd4},   // R4 behaves as divide by 1
        {OP_RD,   A_CTRL, 32'h0,  32'hEE, 8'd2},
        {OP_RD,   A_NONE, 32'h0,  32'h0,  8'd12}   // R12 unmapped offset
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit ended = 1'b0;

    always #2 clk = ~clk;

    cntdn_timer u_cntdn_timer (
        .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    task automatic check(input int req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL R%0d: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic rd_check(input int req, input logic [2:0] a, input logic [31:0] exp);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 check(req, rdata, exp);
        rd_en = 1'b0;
    endtask

    task automatic run_vec(input vec_t v);
        case (v.op)
            OP_WR: begin
                @(negedge clk);
                wr_en = 1'b1; addr = v.a; wdata = v.d;
                @(negedge clk);
                wr_en = 1'b0;
            end
            OP_RD: rd_check(int'(v.req), v.a, v.e);
            OP_TICK, OP_IDLE: begin
                @(negedge clk);
                tick_en = (v.op == OP_TICK);
                repeat (int'(v.d)) @(negedge clk);
                tick_en = 1'b0;
            end
            default: begin
                @(negedge clk);
                #1 check(int'(v.req), {31'b0, irq}, v.e);
            end
        endcase
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < NA; i++) run_vec(vec_t'(TAB_A[i]));
        for (int i = 0; i < NB; i++) run_vec(vec_t'(TAB_B[i]));

        // R12: read strobe low gives zero even on a live offset
        @(negedge clk);
        addr = A_CTRL; rd_en = 1'b0;
        #1 check(12, rdata, 32'h0);

        // R1: reset mid-run restores the idle state
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        rd_check(1, A_CTRL, 32'h20);
        rd_check(1, A_VAL,  32'h0);
        rd_check(1, A_LOAD, 32'h0);
        rd_check(1, A_RAW,  32'h0);
        @(negedge clk);
        #1 check(1, {31'b0, irq}, 32'h0);
        finish_run();
    end

    initial begin
        #400000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

endmodule